// File: doc/BRIEF.md
# UART Auto-Baud Edge-Window Timer

This block measures the bit timing of a known calibration character on a UART receive line. After an enable bit rises, it synchronizes the asynchronous receive input and numbers the transitions it sees on it. Numbering starts with the first falling edge (the start bit leaving the idle-high line). The block counts system clock cycles between a programmable starting edge and a programmable ending edge. Software can pick a window that spans a whole number of bit times, which gives a 20-bit cycle count. Turning that count into divider settings is left to the surrounding logic.

A measurement ends in one of four ways. A done flag means both edges were found. A break timeout means the line stayed low past the cycle limit. A missing-start timeout means the line stayed idle before the starting edge. A missing-end timeout means the ending edge never arrived. The count is presented as a 12-bit low part and an upper part. Two enables gate a single interrupt output. Results stay frozen until the enable is dropped and raised again.

Top module: `uart_autobaud_det`

## Requirements
- R1: After reset, all four result flags, both count fields and the interrupt are 0.
- R2: Edges are taken from the input after a two-flop synchronizer. Edge number 1 is the first falling edge seen after detection starts, and rising edges before it are ignored. Every later transition of either polarity adds one. The starting edge is number `start_sel_i`+1 (values 0..7). The ending edge is number `end_sel_i`+1 (values 0..8).
- R3: When the ending edge is found, `done_o` sets and the count equals the number of clock cycles between the input transition of the starting edge and that of the ending edge.
- R4: The flags and count change on the third rising clock edge after the transition on `rx_i` that completes a measurement. They do not change on the two edges before it.
- R5: If `end_sel_i` is not greater than `start_sel_i` when detection starts, `noend_tmo_o` sets on the same clock edge that samples the enable rise, and the count is 0.
- R6: If the timer reaches `TMO_LIMIT` while the synchronized line is low, `brk_tmo_o` sets and the count reads `TMO_LIMIT`. Before the start edge, the timer restarts at each counted edge. After the start edge, it runs from that edge.
- R7: If the timer reaches `TMO_LIMIT` before the starting edge is found while the line is high, `nostart_tmo_o` sets.
- R8: If the timer reaches `TMO_LIMIT` after the starting edge was found while the line is high, `noend_tmo_o` sets.
- R9: At most one result flag is set at a time. Once set, the flags and count hold through further line activity and through clearing of the enable.
- R10: A rising `en_i` restarts detection and clears all flags and the count on the edge that samples it.
- R11: `irq_o` is high exactly when (`done_o` and `done_ie_i`) or (any timeout flag and `tmo_ie_i`), with no added delay.
- R12: `cnt_lo_o` carries count bits 11:0 and `cnt_hi_o` carries count bits 19:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Receive line, asynchronous, idles high |
| en_i | input | 1 | Detection enable; a rising level restarts detection |
| start_sel_i | input | 3 | Starting edge number minus one |
| end_sel_i | input | 4 | Ending edge number minus one |
| done_ie_i | input | 1 | Lets the done flag raise the interrupt |
| tmo_ie_i | input | 1 | Lets any timeout flag raise the interrupt |
| done_o | output | 1 | Measurement completed |
| brk_tmo_o | output | 1 | Timeout with the line held low |
| nostart_tmo_o | output | 1 | Timeout before the starting edge |
| noend_tmo_o | output | 1 | Timeout or invalid window before the ending edge |
| cnt_lo_o | output | 12 | Measured count, bits 11:0 |
| cnt_hi_o | output | 8 | Measured count, bits 19:12 |
| irq_o | output | 1 | Gated interrupt |

## Verification
A transition on `rx_i` takes effect on the result registers on the third rising edge after it is driven: two edges for the synchronizer and one for the result register. An enable rise is seen on the first edge after it is driven. A timeout lands `TMO_LIMIT` edges after the timer's last restart, and the interrupt follows the flags with no added delay. A behavioural model in the bench applies these same delays. Every output is compared with the model 1 ns after each rising edge. The scenario checks count exact edge numbers from each stimulus before they sample, including a latency check that expects no result on the second edge and a result on the third.

// File: rtl/uab_pkg.sv
package uab_pkg;

  localparam int START_SEL_W = 3;
  localparam int END_SEL_W   = 4;
  localparam int EDGE_CNT_W  = 4;
  localparam int CNT_LO_W    = 12;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_SEEK = 2'd1,
    ST_MEAS = 2'd2,
    ST_HOLD = 2'd3
  } uab_state_e;

  typedef enum logic [1:0] {
    FIN_DONE    = 2'd0,
    FIN_BRK     = 2'd1,
    FIN_NOSTART = 2'd2,
    FIN_NOEND   = 2'd3
  } uab_fin_e;

  // A window is usable only when the ending edge comes after the starting edge.
  function automatic logic window_ok(input logic [START_SEL_W-1:0] s,
                                     input logic [END_SEL_W-1:0]   e);
    return e > {1'b0, s};
  endfunction

  // Cause of an expired timer: a low line is a break, otherwise the phase decides.
  function automatic uab_fin_e fail_kind(input logic in_meas, input logic line);
    if (!line)   return FIN_BRK;
    if (in_meas) return FIN_NOEND;
    return FIN_NOSTART;
  endfunction

endpackage

// File: rtl/uab_edge_sync.sv
module uab_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic line_o,
  output logic any_edge_o,
  output logic fall_edge_o
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= rx_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[LAST];

  assign line_o      = sync_q[LAST];
  assign any_edge_o  = sync_q[LAST] ^ prev_q;
  assign fall_edge_o = prev_q & ~sync_q[LAST];
endmodule

// File: rtl/uab_ctrl.sv
module uab_ctrl
  import uab_pkg::*;
#(
  parameter int CNT_W     = 20,
  parameter int TMO_LIMIT = (1 << 20) - 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_i,
  input  logic [START_SEL_W-1:0] start_sel_i,
  input  logic [END_SEL_W-1:0]   end_sel_i,
  input  logic                   line_i,
  input  logic                   any_edge_i,
  input  logic                   fall_edge_i,
  output logic                   restart_o,
  output logic                   finish_o,
  output uab_fin_e               fin_kind_o,
  output logic [CNT_W-1:0]       fin_count_o,
  output uab_state_e             state_o
);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(TMO_LIMIT);
  localparam logic [CNT_W-1:0] ONE_V   = CNT_W'(1);

  uab_state_e            state_q;
  logic                  en_q;
  logic [CNT_W-1:0]      tmr_q;
  logic [EDGE_CNT_W-1:0] ecnt_q;

  logic restart_w, counted_w, start_hit_w, end_hit_w, tmr_full_w, win_ok_w;

  assign restart_w   = en_i & ~en_q;
  assign win_ok_w    = window_ok(start_sel_i, end_sel_i);
  assign counted_w   = (state_q == ST_SEEK) &&
                       ((ecnt_q == '0) ? fall_edge_i : any_edge_i);
  assign start_hit_w = counted_w && (ecnt_q == EDGE_CNT_W'(start_sel_i));
  assign end_hit_w   = (state_q == ST_MEAS) && any_edge_i &&
                       (ecnt_q == EDGE_CNT_W'(end_sel_i));
  assign tmr_full_w  = (tmr_q == LIMIT_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      en_q    <= 1'b0;
      tmr_q   <= '0;
      ecnt_q  <= '0;
    end else begin
      en_q <= en_i;
      if (restart_w) begin
        tmr_q   <= '0;
        ecnt_q  <= '0;
        state_q <= win_ok_w ? ST_SEEK : ST_HOLD;
      end else if (!en_i) begin
        state_q <= ST_OFF;
      end else begin
        unique case (state_q)
          ST_SEEK: begin
            if (counted_w) begin
              ecnt_q <= ecnt_q + 1'b1;
              tmr_q  <= '0;
              if (start_hit_w) state_q <= ST_MEAS;
            end else if (tmr_full_w) begin
              state_q <= ST_HOLD;
            end else begin
              tmr_q <= tmr_q + ONE_V;
            end
          end
          ST_MEAS: begin
            if (any_edge_i) ecnt_q <= ecnt_q + 1'b1;
            if (end_hit_w || tmr_full_w) state_q <= ST_HOLD;
            else                         tmr_q   <= tmr_q + ONE_V;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    finish_o    = 1'b0;
    fin_kind_o  = FIN_DONE;
    fin_count_o = '0;
    if (restart_w) begin
      if (!win_ok_w) begin
        finish_o   = 1'b1;
        fin_kind_o = FIN_NOEND;
      end
    end else if (en_i) begin
      if (state_q == ST_SEEK && !counted_w && tmr_full_w) begin
        finish_o    = 1'b1;
        fin_kind_o  = fail_kind(1'b0, line_i);
        fin_count_o = tmr_q;
      end else if (state_q == ST_MEAS && end_hit_w) begin
        finish_o    = 1'b1;
        fin_kind_o  = FIN_DONE;
        fin_count_o = tmr_q + ONE_V;
      end else if (state_q == ST_MEAS && tmr_full_w) begin
        finish_o    = 1'b1;
        fin_kind_o  = fail_kind(1'b1, line_i);
        fin_count_o = tmr_q;
      end
    end
  end

  assign restart_o = restart_w;
  assign state_o   = state_q;
endmodule

// File: rtl/uab_status.sv
module uab_status
  import uab_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             finish_i,
  input  uab_fin_e         fin_kind_i,
  input  logic [CNT_W-1:0] fin_count_i,
  input  logic             done_ie_i,
  input  logic             tmo_ie_i,
  output logic             done_o,
  output logic             brk_o,
  output logic             nostart_o,
  output logic             noend_o,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      brk_o     <= 1'b0;
      nostart_o <= 1'b0;
      noend_o   <= 1'b0;
      count_o   <= '0;
    end else begin
      if (restart_i) begin
        done_o    <= 1'b0;
        brk_o     <= 1'b0;
        nostart_o <= 1'b0;
        noend_o   <= 1'b0;
        count_o   <= '0;
      end
      if (finish_i) begin
        count_o <= fin_count_i;
        unique case (fin_kind_i)
          FIN_DONE:    done_o    <= 1'b1;
          FIN_BRK:     brk_o     <= 1'b1;
          FIN_NOSTART: nostart_o <= 1'b1;
          FIN_NOEND:   noend_o   <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign irq_o = (done_o & done_ie_i) | ((brk_o | nostart_o | noend_o) & tmo_ie_i);
endmodule

// File: rtl/uart_autobaud_det.sv
module uart_autobaud_det
  import uab_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int SYNC_STAGES = 2,
  parameter int TMO_LIMIT   = (1 << 20) - 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_i,
  input  logic                      en_i,
  input  logic [START_SEL_W-1:0]    start_sel_i,
  input  logic [END_SEL_W-1:0]      end_sel_i,
  input  logic                      done_ie_i,
  input  logic                      tmo_ie_i,
  output logic                      done_o,
  output logic                      brk_tmo_o,
  output logic                      nostart_tmo_o,
  output logic                      noend_tmo_o,
  output logic [CNT_LO_W-1:0]       cnt_lo_o,
  output logic [CNT_W-CNT_LO_W-1:0] cnt_hi_o,
  output logic                      irq_o
);
  logic             line_w, any_edge_w, fall_edge_w;
  logic             restart_w, finish_w;
  uab_fin_e         fin_kind_w;
  logic [CNT_W-1:0] fin_count_w, count_w;
  uab_state_e       state_w;

  uab_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rx_i(rx_i),
    .line_o(line_w), .any_edge_o(any_edge_w), .fall_edge_o(fall_edge_w)
  );

  uab_ctrl #(.CNT_W(CNT_W), .TMO_LIMIT(TMO_LIMIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en_i),
    .start_sel_i(start_sel_i), .end_sel_i(end_sel_i),
    .line_i(line_w), .any_edge_i(any_edge_w), .fall_edge_i(fall_edge_w),
    .restart_o(restart_w), .finish_o(finish_w), .fin_kind_o(fin_kind_w),
    .fin_count_o(fin_count_w), .state_o(state_w)
  );

  uab_status #(.CNT_W(CNT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .restart_i(restart_w), .finish_i(finish_w),
    .fin_kind_i(fin_kind_w), .fin_count_i(fin_count_w),
    .done_ie_i(done_ie_i), .tmo_ie_i(tmo_ie_i),
    .done_o(done_o), .brk_o(brk_tmo_o), .nostart_o(nostart_tmo_o),
    .noend_o(noend_tmo_o), .count_o(count_w), .irq_o(irq_o)
  );

  assign cnt_lo_o = count_w[CNT_LO_W-1:0];
  assign cnt_hi_o = count_w[CNT_W-1:CNT_LO_W];
endmodule

// File: rtl/uab_chk.sv
module uab_chk
  import uab_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic [START_SEL_W-1:0] start_sel,
  input logic [END_SEL_W-1:0]   end_sel,
  input logic                   done_ie,
  input logic                   done,
  input logic                   brk,
  input logic                   nostart,
  input logic                   noend,
  input logic [CNT_LO_W-1:0]    cnt_lo,
  input logic                   irq,
  input logic                   restart,
  input logic                   finish,
  input uab_fin_e               fin_kind,
  input logic                   any_edge,
  input uab_state_e             state
);
  logic any_flag;
  assign any_flag = done | brk | nostart | noend;

  a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, brk, nostart, noend}));

  a_r9_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
    any_flag && !restart |=> $stable({done, brk, nostart, noend, cnt_lo}));

  a_r10_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !done && !brk && !nostart);

  a_r5_bad_window: assert property (@(posedge clk) disable iff (!rst_n)
    restart && (end_sel <= {1'b0, start_sel}) |=> noend && cnt_lo == '0);

  a_r3_done_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    finish && fin_kind == FIN_DONE |-> any_edge && state == ST_MEAS);

  a_r7_nostart_in_seek: assert property (@(posedge clk) disable iff (!rst_n)
    finish && fin_kind == FIN_NOSTART |-> state == ST_SEEK);

  a_r11_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
    finish && fin_kind == FIN_DONE && done_ie && !restart |=> irq || !done_ie);
endmodule

bind uart_autobaud_det uab_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_sel(start_sel_i), .end_sel(end_sel_i),
  .done_ie(done_ie_i), .done(done_o), .brk(brk_tmo_o), .nostart(nostart_tmo_o),
  .noend(noend_tmo_o), .cnt_lo(cnt_lo_o), .irq(irq_o), .restart(restart_w),
  .finish(finish_w), .fin_kind(fin_kind_w), .any_edge(any_edge_w), .state(state_w)
);

// File: tb/tb_uart_autobaud_det.sv
`timescale 1ns/1ps
module tb_uart_autobaud_det;
  localparam int LIM = 5000;

  logic clk = 1'b0, rst_n = 1'b0, rx_i = 1'b1, en_i = 1'b0;
  logic [2:0] start_sel_i = '0;
  logic [3:0] end_sel_i = '0;
  logic done_ie_i = 1'b0, tmo_ie_i = 1'b0;
  logic done_o, brk_tmo_o, nostart_tmo_o, noend_tmo_o, irq_o;
  logic [11:0] cnt_lo_o;
  logic [7:0]  cnt_hi_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uart_autobaud_det #(.TMO_LIMIT(LIM)) dut (.*);

  // Behavioural reference model
  int m_s0, m_s1, m_d, m_enq, ph, tmr, ecnt, m_cnt;
  bit m_done, m_brk, m_nst, m_nend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s0 = 1; m_s1 = 1; m_d = 1; m_enq = 0; ph = 0; tmr = 0; ecnt = 0;
      m_cnt = 0; m_done = 0; m_brk = 0; m_nst = 0; m_nend = 0;
    end else begin
      bit edg, fal;
      edg = (m_s1 != m_d);
      fal = (m_d == 1 && m_s1 == 0);
      if (en_i && !m_enq) begin
        {m_done, m_brk, m_nst, m_nend} = 4'b0; m_cnt = 0; tmr = 0; ecnt = 0;
        if (int'(end_sel_i) <= int'(start_sel_i)) begin ph = 3; m_nend = 1; end
        else ph = 1;
      end else if (!en_i) ph = 0;
      else if (ph == 1) begin
        if ((ecnt == 0) ? fal : edg) begin
          ecnt++; tmr = 0;
          if (ecnt == int'(start_sel_i) + 1) ph = 2;
        end else if (tmr == LIM) begin
          if (m_s1 == 0) m_brk = 1; else m_nst = 1;
          m_cnt = tmr; ph = 3;
        end else tmr++;
      end else if (ph == 2) begin
        if (edg && ecnt + 1 == int'(end_sel_i) + 1) begin
          m_done = 1; m_cnt = tmr + 1; ph = 3;
        end else if (tmr == LIM) begin
          if (m_s1 == 0) m_brk = 1; else m_nend = 1;
          m_cnt = tmr; ph = 3;
        end else tmr++;
        if (edg) ecnt++;
      end
      m_d = m_s1; m_s1 = m_s0; m_s0 = rx_i; m_enq = en_i;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) begin
      int mi;
      mi = (m_done & done_ie_i) | ((m_brk | m_nst | m_nend) & tmo_ie_i);
      check(done_o == m_done, "R3 done", done_o, m_done);
      check(brk_tmo_o == m_brk, "R6 brk", brk_tmo_o, m_brk);
      check(nostart_tmo_o == m_nst, "R7 nostart", nostart_tmo_o, m_nst);
      check(noend_tmo_o == m_nend, "R8 noend", noend_tmo_o, m_nend);
      check({cnt_hi_o, cnt_lo_o} == m_cnt, "R3 count", {cnt_hi_o, cnt_lo_o}, m_cnt);
      check(irq_o == mi, "R11 irq", irq_o, mi);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input int s, input int e);
    en_i = 1'b0; tick(1);
    start_sel_i = 3'(s); end_sel_i = 4'(e); en_i = 1'b1; tick(1);
  endtask

  function automatic int cnt_now();
    return {cnt_hi_o, cnt_lo_o};
  endfunction

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check({done_o, brk_tmo_o, nostart_tmo_o, noend_tmo_o, irq_o} == 0, "R1 flags", done_o, 0);
    check(cnt_now() == 0, "R1 count", cnt_now(), 0);

    // edge 1 -> edge 2, low pulse of 40 cycles, with latency check
    restart(0, 1); tick(5);
    rx_i = 1'b0; tick(40); rx_i = 1'b1;
    tick(2);
    check(done_o == 0, "R4 not yet", done_o, 0);
    tick(1);
    check(done_o == 1, "R4 third edge", done_o, 1);
    check(cnt_now() == 40, "R3 count", cnt_now(), 40);

    // hold through activity and through enable drop
    rx_i = 1'b0; tick(10); rx_i = 1'b1; tick(5);
    check(done_o == 1 && cnt_now() == 40, "R9 hold active", cnt_now(), 40);
    en_i = 1'b0; tick(4);
    check(done_o == 1 && cnt_now() == 40, "R9 hold disabled", cnt_now(), 40);

    // restart clears, then idle line -> missing start edge
    en_i = 1'b1; tick(1);
    check(done_o == 0 && cnt_now() == 0, "R10 cleared", cnt_now(), 0);
    tick(LIM + 5);
    check(nostart_tmo_o == 1, "R7 flag", nostart_tmo_o, 1);
    check(cnt_now() == LIM, "R7 count", cnt_now(), LIM);
    check(irq_o == 0, "R11 masked", irq_o, 0);
    tmo_ie_i = 1'b1; #1;
    check(irq_o == 1, "R11 tmo enable", irq_o, 1);
    tmo_ie_i = 1'b0;

    // leading rising edge ignored; edge 3 -> edge 7 of alternating bits
    rx_i = 1'b0; tick(6);
    restart(2, 6); tick(5);
    rx_i = 1'b1; tick(8);
    for (int i = 0; i < 8; i++) begin
      rx_i = i[0]; tick(16);
    end
    rx_i = 1'b1; tick(10);
    check(done_o == 1, "R2 done", done_o, 1);
    check(cnt_now() == 64, "R2 window", cnt_now(), 64);

    // long pulse exercises the high count field and done interrupt
    done_ie_i = 1'b1;
    restart(0, 1); tick(3);
    rx_i = 1'b0; tick(4100); rx_i = 1'b1; tick(5);
    check(cnt_lo_o == 12'd4, "R12 low part", cnt_lo_o, 4);
    check(cnt_hi_o == 8'd1, "R12 high part", cnt_hi_o, 1);
    check(irq_o == 1, "R11 done irq", irq_o, 1);
    done_ie_i = 1'b0;

    // invalid window
    restart(3, 3);
    check(noend_tmo_o == 1 && cnt_now() == 0, "R5 bad window", noend_tmo_o, 1);

    // break: line stays low after the start edge
    restart(0, 1); tick(3);
    rx_i = 1'b0; tick(LIM + 10);
    check(brk_tmo_o == 1, "R6 break", brk_tmo_o, 1);
    check(cnt_now() == LIM, "R6 count", cnt_now(), LIM);

    // missing end edge: line high after edge 2, end is edge 3
    rx_i = 1'b1; tick(4);
    restart(0, 2); tick(3);
    rx_i = 1'b0; tick(10); rx_i = 1'b1; tick(LIM + 10);
    check(noend_tmo_o == 1, "R8 noend", noend_tmo_o, 1);
    check(done_o == 0 && brk_tmo_o == 0, "R9 exclusive", done_o, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule